// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer for a system-on-chip, reached through a small 16-bit register window with a plain write strobe and a combinational read path. Software loads a timeout in half-second units and turns the timer on. From then on the timer counts down once per half-second tick, and software cannot switch it off again. Only a two-word keyed service sequence reloads it. If the count runs out, the block raises a reset request. A routing bit in the control register selects whether that request goes to the on-chip reset logic or to an active-low pin that leaves the chip.

An optional early-warning interrupt fires a programmable number of half-seconds before expiry. A status bit records whether the last reset came from an expiry; it survives the system reset that this block itself requests. Software can also ask for either kind of reset directly through two active-low bits. A boot-time power-down counter pulses the interrupt line low once unless software turns it off. The half-second tick is an input strobe, so a system or a bench can scale time freely. There are two reset inputs. The power-on reset clears everything. The system reset clears everything except the expiry record.

Register offsets are 0x0 control, 0x2 service, 0x4 reset status, 0x6 interrupt control and 0x8 miscellaneous. Control holds the timeout in bits 15:8, the active-low external-reset bit in bit 5, the active-low software-reset bit in bit 4, the routing select in bit 3, the enable in bit 2 and the sleep-freeze bit in bit 0; bits 7:6 and 1 read 0.

Top module: `kwd_top`

## Requirements
- R1: After reset, control reads 0x0030, status, interrupt control and service read 0x0000, miscellaneous reads 0x0001, int_rst_req is 0, and ext_rst_n and irq_n are 1.
- R2: A timeout field value N makes the timer expire on the (N+1)th tick after it was loaded. It is loaded by the enabling write (with the value in that write), by a valid service sequence, and by each expiry.
- R3: Writing 0x5555 and then 0xAAAA to the service register reloads the counter. Any other service write clears the armed state with no reload, and a 0x5555 write always arms the checker again.
- R4: Control bit 2 (enable), once set, stays set until a reset; writing 0 to it has no effect.
- R5: Control bit 0 (sleep-freeze) takes its value from the first control write after reset only. While it is 1 and sleep_i is high, ticks do not advance the counter.
- R6: On expiry with control bit 3 clear, int_rst_req is high for HOLD_CYC cycles, starting in the cycle after the expiring tick, and ext_rst_n stays 1. With bit 3 set, ext_rst_n is low for HOLD_CYC cycles and int_rst_req stays 0.
- R7: Writing 0 to control bit 4 gives an int_rst_req pulse of HOLD_CYC cycles. Writing 0 to bit 5 gives an ext_rst_n low pulse of HOLD_CYC cycles. Both bits read back as 1.
- R8: With interrupt-control bit 15 set, bit 14 sets on the tick that brings the count down to the value in bits 7:0. irq_n is low while bits 14 and 15 are both set, and writing 1 to bit 14 clears it.
- R9: Status bit 1 is set by an expiry and cleared by a software-reset request. It survives rst_n and is cleared only by por_n.
- R10: If miscellaneous bit 0 is still 1, irq_n goes low for exactly one cycle after the PDC_TICKS-th tick since reset. Writing 0x0000 to the miscellaneous register clears that bit and suppresses the pulse.
- R11: While the enable bit is 0, no expiry and no expiry-driven reset occur, whatever ticks arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | System reset, active low, keeps the expiry record |
| tick_i | input | 1 | One-cycle half-second strobe |
| sleep_i | input | 1 | Low-power indication from the system |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| int_rst_req | output | 1 | Internal reset request, active high |
| ext_rst_n | output | 1 | External reset output, active low |
| irq_n | output | 1 | Pre-timeout / power-down interrupt, active low |

## Verification
The bound checker watches some behaviours on every cycle. It checks that the enable bit cannot fall, that no expiry happens while the timer is off, and that reset pulses last longer than one cycle. It also checks that a completed service sequence disarms the checker, that an expiry always leaves the status bit set, that an active pre-timeout flag holds irq_n low, and that a power-down pulse lasts only one cycle. Other behaviours are sequences that only the bench scenarios can show. These are the exact tick on which the timer expires, reload through a broken or a restarted key sequence, the sleep-freeze lock, survival of the status bit through a system reset, and disabling of the power-down counter. The bench checks them with a behavioural model compared on every clock and with targeted register reads.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] A_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h4;
  localparam logic [ADDR_W-1:0] A_ICR  = 4'h6;
  localparam logic [ADDR_W-1:0] A_MISC = 4'h8;

  localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;

  localparam int B_EXTN  = 5;
  localparam int B_SRSN  = 4;
  localparam int B_ROUTE = 3;
  localparam int B_EN    = 2;
  localparam int B_FRZ   = 0;
  localparam int B_TOUT  = 1;
  localparam int B_IE    = 15;
  localparam int B_PREF  = 14;

  localparam int PATH_INT = 0;
  localparam int PATH_EXT = 1;
  localparam int NPATH    = 2;

  typedef struct packed {
    logic [7:0] tmo;
    logic       route;
    logic       en;
    logic       frz;
    logic       frz_lock;
  } ctrl_t;
endpackage

// File: rtl/kwd_svc_check.sv
module kwd_svc_check
  import kwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  output logic              armed,
  output logic              reload
);
  // ordered key: first word arms, second word fires only when armed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (wr) armed <= (data == KEY_ARM);
  end

  assign reload = wr && (data == KEY_FIRE) && armed;
endmodule

// File: rtl/kwd_countdown.sv
module kwd_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] lead,
  output logic         expire,
  output logic         near
);
  logic [W-1:0] cnt;
  logic         step;

  assign step   = run && tick;
  assign expire = step && (cnt == '0);
  assign near   = step && (cnt != '0) && ((cnt - W'(1)) == lead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '1;
    else if (load || expire)   cnt <= load_val;
    else if (step)             cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/kwd_hold.sv
module kwd_hold #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int HW = $clog2(HOLD + 1);
  logic [HW-1:0] hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hcnt <= '0;
    else if (fire)       hcnt <= HW'(HOLD);
    else if (hcnt != '0) hcnt <= hcnt - HW'(1);
  end

  assign active = (hcnt != '0);
endmodule

// File: rtl/kwd_pdc.sv
module kwd_pdc #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  output logic pulse
);
  localparam int PW = (TICKS > 1) ? $clog2(TICKS) : 1;
  logic [PW-1:0] cnt;
  logic          done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      done  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (en && !done && tick) begin
        if (cnt == PW'(TICKS - 1)) begin
          done  <= 1'b1;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int HOLD_CYC  = 4,
  parameter int PDC_TICKS = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sleep_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              int_rst_req,
  output logic              ext_rst_n,
  output logic              irq_n
);
  localparam int TW = 8;

  logic          sys_rst_n;
  ctrl_t         ctrl_q;
  logic          ie_q, pref_q, tout_q, pdc_en_q;
  logic [TW-1:0] lead_q, tmo_nxt;
  logic          wr_ctrl, wr_svc, wr_icr, wr_misc;
  logic          en_rise, run, load, expire, near;
  logic          svc_armed, svc_reload, srs_req, pdc_pulse;
  logic          en_w;
  logic [NPATH-1:0] fire, held;
  logic          unused_bits;

  assign sys_rst_n = rst_n & por_n;
  assign unused_bits = ^{bus_wdata[7:6], bus_wdata[1]};

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_svc  = bus_wr && (bus_addr == A_SVC);
  assign wr_icr  = bus_wr && (bus_addr == A_ICR);
  assign wr_misc = bus_wr && (bus_addr == A_MISC);

  assign tmo_nxt = wr_ctrl ? bus_wdata[15:8] : ctrl_q.tmo;
  assign en_rise = wr_ctrl && bus_wdata[B_EN] && !ctrl_q.en;
  assign run     = ctrl_q.en && !(ctrl_q.frz && sleep_i);
  assign load    = svc_reload || en_rise;
  assign srs_req = wr_ctrl && !bus_wdata[B_SRSN];
  assign en_w    = ctrl_q.en;

  // control register: sticky enable, write-once freeze bit
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.tmo   <= bus_wdata[15:8];
      ctrl_q.route <= bus_wdata[B_ROUTE];
      if (bus_wdata[B_EN]) ctrl_q.en <= 1'b1;
      if (!ctrl_q.frz_lock) begin
        ctrl_q.frz      <= bus_wdata[B_FRZ];
        ctrl_q.frz_lock <= 1'b1;
      end
    end
  end

  // interrupt control: enable, lead time, write-one-to-clear flag
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ie_q   <= 1'b0;
      lead_q <= '0;
      pref_q <= 1'b0;
    end else begin
      if (wr_icr) begin
        ie_q   <= bus_wdata[B_IE];
        lead_q <= bus_wdata[TW-1:0];
      end
      if (near && ie_q)                  pref_q <= 1'b1;
      else if (wr_icr && bus_wdata[B_PREF]) pref_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)                     pdc_en_q <= 1'b1;
    else if (wr_misc && bus_wdata == '0) pdc_en_q <= 1'b0;
  end

  // expiry record lives in the power-on domain only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       tout_q <= 1'b0;
    else if (expire)  tout_q <= 1'b1;
    else if (srs_req) tout_q <= 1'b0;
  end

  kwd_svc_check u_svc (
    .clk    (clk),
    .rst_n  (sys_rst_n),
    .wr     (wr_svc),
    .data   (bus_wdata),
    .armed  (svc_armed),
    .reload (svc_reload)
  );

  kwd_countdown #(.W(TW)) u_cnt (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .run      (run),
    .tick     (tick_i),
    .load     (load),
    .load_val (tmo_nxt),
    .lead     (lead_q),
    .expire   (expire),
    .near     (near)
  );

  assign fire[PATH_INT] = (expire && !ctrl_q.route) || srs_req;
  assign fire[PATH_EXT] = (expire &&  ctrl_q.route) || (wr_ctrl && !bus_wdata[B_EXTN]);

  for (genvar g = 0; g < NPATH; g++) begin : g_hold
    kwd_hold #(.HOLD(HOLD_CYC)) u_hold (
      .clk    (clk),
      .rst_n  (sys_rst_n),
      .fire   (fire[g]),
      .active (held[g])
    );
  end

  kwd_pdc #(.TICKS(PDC_TICKS)) u_pdc (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .en    (pdc_en_q),
    .tick  (tick_i),
    .pulse (pdc_pulse)
  );

  assign int_rst_req = held[PATH_INT];
  assign ext_rst_n   = !held[PATH_EXT];
  assign irq_n       = !((pref_q && ie_q) || pdc_pulse);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = {ctrl_q.tmo, 2'b00, 2'b11, ctrl_q.route, ctrl_q.en, 1'b0, ctrl_q.frz};
      A_STAT: bus_rdata = {14'b0, tout_q, 1'b0};
      A_ICR:  bus_rdata = {ie_q, pref_q, 6'b0, lead_q};
      A_MISC: bus_rdata = {15'b0, pdc_en_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic expire,
  input logic armed,
  input logic reload,
  input logic tout,
  input logic pref,
  input logic ie,
  input logic int_rst_req,
  input logic ext_rst_n,
  input logic irq_n
);
  // R4
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) en |=> en);
  // R11
  idle_no_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n) !en |-> !expire);
  // R3
  key_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n) reload |=> !armed);
  // R9
  tout_record_chk: assert property (@(posedge clk) disable iff (!rst_n) expire |=> tout);
  // R6
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(int_rst_req) |=> int_rst_req);
  // R6
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(ext_rst_n) |=> !ext_rst_n);
  // R8
  pre_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) (pref && ie) |-> !irq_n);
  // R10
  pdc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !(pref && ie)) |=> (irq_n || (pref && ie)));
endmodule

bind kwd_top kwd_chk u_chk (
  .clk         (clk),
  .rst_n       (sys_rst_n),
  .en          (en_w),
  .expire      (expire),
  .armed       (svc_armed),
  .reload      (svc_reload),
  .tout        (tout_q),
  .pref        (pref_q),
  .ie          (ie_q),
  .int_rst_req (int_rst_req),
  .ext_rst_n   (ext_rst_n),
  .irq_n       (irq_n)
);

// File: tb/kwd_top_tb_top.sv
module kwd_top_tb_top;
  localparam int HOLD = 4;
  localparam int PDC  = 16;

  logic        clk = 0;
  logic        por_n = 0, rst_n = 0, tick_i = 0, sleep_i = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        int_rst_req, ext_rst_n, irq_n;

  always #2.5 clk = ~clk;

  kwd_top #(.HOLD_CYC(HOLD), .PDC_TICKS(PDC)) dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_i(tick_i), .sleep_i(sleep_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .int_rst_req(int_rst_req), .ext_rst_n(ext_rst_n), .irq_n(irq_n)
  );

  int total = 0, bad = 0, cycles = 0;
  int int_rises = 0, ext_falls = 0, irq_lows = 0;
  logic p_int = 0, p_ext = 1, p_irq = 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_tmo, m_cnt, m_lead, m_int, m_ext, m_pdc_cnt;
  bit m_route, m_en, m_frz, m_lock, m_ie, m_flag, m_tout, m_armed, m_pdc_en, m_pdc_done, m_pulse;

  task automatic mreset(input bit full);
    m_tmo = 0; m_cnt = 255; m_lead = 0; m_int = 0; m_ext = 0; m_pdc_cnt = 0;
    m_route = 0; m_en = 0; m_frz = 0; m_lock = 0; m_ie = 0; m_flag = 0;
    m_armed = 0; m_pdc_en = 1; m_pdc_done = 0; m_pulse = 0;
    if (full) m_tout = 0;
  endtask

  always @(posedge clk) begin
    bit wctl, wsvc, wicr, wmisc, run, ex, nr, ok, er, srs, extw;
    int tnext;
    if (!por_n) mreset(1);
    else if (!rst_n) mreset(0);
    else begin
      wctl  = bus_wr && bus_addr == 4'h0;
      wsvc  = bus_wr && bus_addr == 4'h2;
      wicr  = bus_wr && bus_addr == 4'h6;
      wmisc = bus_wr && bus_addr == 4'h8;
      run   = m_en && !(m_frz && sleep_i);
      ex    = run && tick_i && m_cnt == 0;
      nr    = run && tick_i && m_cnt != 0 && (m_cnt - 1) == m_lead && m_ie;
      tnext = wctl ? int'(bus_wdata[15:8]) : m_tmo;
      srs   = wctl && !bus_wdata[4];
      extw  = wctl && !bus_wdata[5];
      ok    = wsvc && bus_wdata == 16'hAAAA && m_armed;
      er    = wctl && bus_wdata[2] && !m_en;
      m_int = ((ex && !m_route) || srs) ? HOLD : (m_int > 0 ? m_int - 1 : 0);
      m_ext = ((ex && m_route) || extw) ? HOLD : (m_ext > 0 ? m_ext - 1 : 0);
      if (ok || er || ex) m_cnt = tnext;
      else if (run && tick_i) m_cnt = m_cnt - 1;
      if (ex) m_tout = 1; else if (srs) m_tout = 0;
      if (nr) m_flag = 1; else if (wicr && bus_wdata[14]) m_flag = 0;
      if (wicr) begin m_ie = bus_wdata[15]; m_lead = int'(bus_wdata[7:0]); end
      if (wctl) begin
        m_tmo = tnext; m_route = bus_wdata[3];
        if (bus_wdata[2]) m_en = 1;
        if (!m_lock) begin m_frz = bus_wdata[0]; m_lock = 1; end
      end
      if (wsvc) m_armed = (bus_wdata == 16'h5555);
      m_pulse = 0;
      if (m_pdc_en && !m_pdc_done && tick_i) begin
        if (m_pdc_cnt == PDC - 1) begin m_pdc_done = 1; m_pulse = 1; end
        else m_pdc_cnt++;
      end
      if (wmisc && bus_wdata == 16'h0) m_pdc_en = 0;
    end
  end

  // per-cycle comparison and edge monitors
  always @(negedge clk) begin
    cycles++;
    if (por_n && rst_n) begin
      chk(int_rst_req == (m_int > 0), "R6 R7 model int_rst_req", int_rst_req, m_int > 0);
      chk(ext_rst_n == !(m_ext > 0), "R6 R7 model ext_rst_n", ext_rst_n, !(m_ext > 0));
      chk(irq_n == !((m_flag && m_ie) || m_pulse), "R8 R10 model irq_n", irq_n,
          !((m_flag && m_ie) || m_pulse));
    end
    if (int_rst_req && !p_int) int_rises++;
    if (!ext_rst_n && p_ext) ext_falls++;
    if (!irq_n && p_irq) irq_lows++;
    p_int = int_rst_req; p_ext = ext_rst_n; p_irq = irq_n;
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1;
      @(negedge clk); tick_i = 0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic service(input logic [15:0] a, input logic [15:0] b);
    wr(4'h2, a); wr(4'h2, b);
  endtask

  initial begin
    #400000;
    chk(0, "watchdog expired", cycles, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int b;
    idle(4); por_n = 1; rst_n = 1; idle(2);

    rd(4'h0, v); chk(v == 16'h0030, "R1 ctrl reset", v, 16'h0030);
    rd(4'h4, v); chk(v == 16'h0000, "R1 status reset", v, 0);
    rd(4'h6, v); chk(v == 16'h0000, "R1 icr reset", v, 0);
    rd(4'h8, v); chk(v == 16'h0001, "R1 misc reset", v, 1);
    chk(irq_n && ext_rst_n && !int_rst_req, "R1 outputs reset",
        {irq_n, ext_rst_n, int_rst_req}, 3'b110);

    b = irq_lows; ticks(PDC); idle(3);
    chk(irq_lows - b == 1, "R10 power-down pulse", irq_lows - b, 1);

    b = int_rises; ticks(10); idle(2);
    chk(int_rises - b == 0, "R11 disabled no expiry", int_rises - b, 0);

    wr(4'h0, 16'h0335); sleep_i = 1;
    b = int_rises; ticks(10); idle(2);
    chk(int_rises - b == 0, "R5 frozen while asleep", int_rises - b, 0);
    wr(4'h0, 16'h0334); rd(4'h0, v);
    chk(v[0] == 1'b1, "R5 freeze bit write-once", v[0], 1);
    sleep_i = 0;

    b = int_rises; ticks(3); idle(2);
    chk(int_rises - b == 0, "R2 no expiry after N ticks", int_rises - b, 0);
    b = ext_falls; ticks(1); idle(2);
    chk(int_rises - (b - b) > 0, "R2 expiry on N+1", int_rises, 1);
    chk(ext_falls - b == 0, "R6 route internal keeps ext high", ext_falls - b, 0);
    rd(4'h4, v); chk(v == 16'h0002, "R9 status after expiry", v, 2);

    wr(4'h0, 16'h0330); rd(4'h0, v);
    chk(v[2] == 1'b1, "R4 enable sticky", v[2], 1);

    idle(6); @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(1);
    rd(4'h4, v); chk(v == 16'h0002, "R9 survives system reset", v, 2);
    rd(4'h0, v); chk(v == 16'h0030, "R1 ctrl after system reset", v, 16'h0030);

    wr(4'h0, 16'h0534); ticks(4); service(16'h5555, 16'hAAAA);
    b = int_rises; ticks(5); idle(2);
    chk(int_rises - b == 0, "R3 valid key reloads", int_rises - b, 0);
    ticks(1); idle(2);
    chk(int_rises - b == 1, "R3 expiry after reload", int_rises - b, 1);
    idle(4); ticks(2);
    wr(4'h2, 16'h5555); wr(4'h2, 16'h1234); wr(4'h2, 16'hAAAA);
    b = int_rises; ticks(4); idle(2);
    chk(int_rises - b == 1, "R3 broken key no reload", int_rises - b, 1);
    idle(4); ticks(3);
    wr(4'h2, 16'h5555); service(16'h5555, 16'hAAAA);
    b = int_rises; ticks(5); idle(2);
    chk(int_rises - b == 0, "R3 re-armed key reloads", int_rises - b, 0);
    ticks(1); idle(2);
    chk(int_rises - b == 1, "R3 expiry after re-arm", int_rises - b, 1);
    idle(4);

    wr(4'h0, 16'h013C); service(16'h5555, 16'hAAAA);
    b = ext_falls; v = 16'(int_rises); ticks(2); idle(2);
    chk(ext_falls - b == 1, "R6 route external", ext_falls - b, 1);
    chk(int_rises == int'(v), "R6 route external no int", int_rises, v);
    idle(4);

    b = int_rises; wr(4'h0, 16'h012C); idle(1);
    chk(int_rises - b == 1, "R7 software internal reset", int_rises - b, 1);
    rd(4'h4, v); chk(v == 16'h0000, "R9 cleared by software reset", v, 0);
    idle(4); b = ext_falls; wr(4'h0, 16'h011C); idle(1);
    chk(ext_falls - b == 1, "R7 software external reset", ext_falls - b, 1);
    rd(4'h0, v); chk(v[5:4] == 2'b11, "R7 active-low bits read 1", v[5:4], 3);
    idle(4);

    wr(4'h6, 16'h8002); wr(4'h0, 16'h053C); service(16'h5555, 16'hAAAA);
    ticks(2); idle(1);
    chk(irq_n == 1'b1, "R8 no flag before lead", irq_n, 1);
    ticks(1); idle(1);
    chk(irq_n == 1'b0, "R8 flag at lead", irq_n, 0);
    rd(4'h6, v); chk(v == 16'hC002, "R8 icr flag set", v, 16'hC002);
    wr(4'h6, 16'hC002); idle(1);
    chk(irq_n == 1'b1, "R8 flag cleared", irq_n, 1);
    rd(4'h6, v); chk(v == 16'h8002, "R8 icr after clear", v, 16'h8002);

    @(negedge clk); por_n = 0; idle(2); por_n = 1; idle(1);
    rd(4'h4, v); chk(v == 16'h0000, "R9 cleared by power-on reset", v, 0);
    wr(4'h8, 16'h0000); rd(4'h8, v);
    chk(v == 16'h0000, "R10 misc disabled", v, 0);
    b = irq_lows; ticks(PDC + 4); idle(2);
    chk(irq_lows - b == 0, "R10 no pulse when disabled", irq_lows - b, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule